// File: doc/BRIEF.md
# Outbound Address Window Translator

The block turns a CPU-side physical address into a bus address through a set of programmable outbound windows, four by default. Each window holds a CPU base and an inclusive CPU limit, both counted in whole megabytes, plus a 64-bit target bus address. An address is tested against every window. If it lands inside one, the block reports a hit and the index of that window. The output address is then the window's target plus the byte offset of the address from the start of the window. If no window matches, the block raises a miss flag and passes the address through unchanged.

Software programs the windows through a word-addressed register port. Each target address is split into a low word and a high word. The low twelve bits of the megabyte base and limit share one packed word, and the top eight bits of each sit in registers of their own. A combinational read port returns any register. A lookup is presented with a valid strobe. In the default build its result is registered and appears one cycle later. A parameter selects a purely combinational variant instead.

Top module: `obwin_xlate`

## Requirements
- R1: Four windows are provided. Window n keeps its target bus address bits 31:0 at word index 2n and bits 63:32 at word index 2n+1. Both read back as written.
- R2: The packed span word of window n sits at word index 8+n. Bits 15:4 hold base megabyte bits 11:0 and bits 31:20 hold limit megabyte bits 11:0. The remaining bits read as zero and ignore writes.
- R3: Base megabyte bits 19:12 of window n sit in bits 7:0 of word index 12+2n, and limit megabyte bits 19:12 in bits 7:0 of word index 13+2n. Bits 31:8 of these words read as zero.
- R4: After reset the target is 0, the base is 0xFFFFF and the limit is 0, so every window is disabled. out_valid, hit and miss are low.
- R5: The megabyte number of a CPU address is cpu_addr[39:20]. A window matches when that number is at least its base and at most its limit, both ends included.
- R6: On a hit, bus_addr = target + (cpu_addr − base × 2^20), wrapping modulo 2^64.
- R7: When several windows match, the lowest-numbered window is reported and used.
- R8: A window whose limit is below its base never matches.
- R9: On a miss, miss is 1, hit is 0, win_idx is 0 and bus_addr equals cpu_addr zero-extended. hit and miss are never high together.
- R10: With the registered output, a lookup presented with in_valid at one clock edge gives out_valid and exactly one of hit or miss after that edge. With no lookup presented, out_valid, hit and miss are all low.
- R11: Writes to word indices 20 to 31 change no register, and reads of them return zero.
- R12: A lookup presented in the same cycle as a register write uses the old configuration. A lookup presented in the next cycle uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Word index of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Word index of the read |
| rd_data | output | 32 | Read data, combinational |
| in_valid | input | 1 | Lookup request |
| cpu_addr | input | 40 | CPU physical address to translate |
| out_valid | output | 1 | Lookup result valid |
| hit | output | 1 | A window matched |
| miss | output | 1 | No window matched |
| win_idx | output | 2 | Index of the matching window |
| bus_addr | output | 64 | Translated or passed-through address |

## Verification
Some properties are checked on every cycle, on the output ports alone. These are that a valid result carries exactly one of hit or miss, that the flags stay low without a lookup, the one-cycle valid latency, and that a miss returns index zero with the unchanged address. Other behaviour needs a model of the window registers. This covers which window wins among overlapping ones, where the inclusive limit falls, how disabled windows behave, the arithmetic of the translation including wrap-around, and the exact cycle from which a register write takes effect. Only the bench's directed and random scenarios, checked against its own model, can show these.

// File: rtl/obwin_pkg.sv
package obwin_pkg;

   localparam int unsigned MB_SHIFT = 20;
   localparam int unsigned MB_LO_W  = 12;
   localparam int unsigned MB_HI_W  = 8;
   localparam int unsigned MB_W     = MB_LO_W + MB_HI_W;
   localparam int unsigned CPU_AW   = MB_SHIFT + MB_W;
   localparam int unsigned TGT_W    = 64;

   typedef enum logic [2:0] {
      RK_NONE,
      RK_TGT_LO,
      RK_TGT_HI,
      RK_SPAN,
      RK_BASE_HI,
      RK_LIM_HI
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e   kind;
      logic [7:0]  win;
   } reg_dec_t;

   typedef struct packed {
      logic [TGT_W-1:0] tgt;
      logic [MB_W-1:0]  base_mb;
      logic [MB_W-1:0]  lim_mb;
   } win_cfg_t;

   // Word map: targets at 2n/2n+1, span words after them, high bytes last.
   function automatic reg_dec_t decode_word(input int unsigned word,
                                            input int unsigned nwin);
      reg_dec_t d;
      int unsigned rel;
      d.kind = RK_NONE;
      d.win  = '0;
      if (word < 2 * nwin) begin
         d.win  = 8'(word >> 1);
         d.kind = word[0] ? RK_TGT_HI : RK_TGT_LO;
      end else if (word < 3 * nwin) begin
         d.win  = 8'(word - 2 * nwin);
         d.kind = RK_SPAN;
      end else if (word < 5 * nwin) begin
         rel    = word - 3 * nwin;
         d.win  = 8'(rel >> 1);
         d.kind = rel[0] ? RK_LIM_HI : RK_BASE_HI;
      end
      return d;
   endfunction

endpackage

// File: rtl/obwin_regs.sv
module obwin_regs
   import obwin_pkg::*;
#(
   parameter int unsigned NUM_WIN = 4,
   parameter int unsigned WA_W    = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [WA_W-1:0]               wr_addr,
   input  logic [31:0]                   wr_data,
   input  logic [WA_W-1:0]               rd_addr,
   output logic [31:0]                   rd_data,
   output win_cfg_t [NUM_WIN-1:0]        cfg
);

   localparam logic [MB_W-1:0] BASE_RST = '1;
   localparam logic [MB_W-1:0] LIM_RST  = '0;

   win_cfg_t [NUM_WIN-1:0] cfg_q;
   reg_dec_t               wr_dec;
   reg_dec_t               rd_dec;

   assign wr_dec = decode_word(int'(wr_addr), NUM_WIN);
   assign rd_dec = decode_word(int'(rd_addr), NUM_WIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < NUM_WIN; w++) begin
            cfg_q[w].tgt     <= '0;
            cfg_q[w].base_mb <= BASE_RST;
            cfg_q[w].lim_mb  <= LIM_RST;
         end
      end else if (wr_en) begin
         for (int w = 0; w < NUM_WIN; w++) begin
            if (int'(wr_dec.win) == w) begin
               case (wr_dec.kind)
                  RK_TGT_LO:  cfg_q[w].tgt[31:0]  <= wr_data;
                  RK_TGT_HI:  cfg_q[w].tgt[63:32] <= wr_data;
                  RK_SPAN: begin
                     cfg_q[w].base_mb[MB_LO_W-1:0] <= wr_data[15:4];
                     cfg_q[w].lim_mb[MB_LO_W-1:0]  <= wr_data[31:20];
                  end
                  RK_BASE_HI: cfg_q[w].base_mb[MB_W-1:MB_LO_W] <= wr_data[7:0];
                  RK_LIM_HI:  cfg_q[w].lim_mb[MB_W-1:MB_LO_W]  <= wr_data[7:0];
                  default: ;
               endcase
            end
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int w = 0; w < NUM_WIN; w++) begin
         if (int'(rd_dec.win) == w) begin
            case (rd_dec.kind)
               RK_TGT_LO:  rd_data = cfg_q[w].tgt[31:0];
               RK_TGT_HI:  rd_data = cfg_q[w].tgt[63:32];
               RK_SPAN:    rd_data = {cfg_q[w].lim_mb[MB_LO_W-1:0], 4'h0,
                                      cfg_q[w].base_mb[MB_LO_W-1:0], 4'h0};
               RK_BASE_HI: rd_data = {24'h0, cfg_q[w].base_mb[MB_W-1:MB_LO_W]};
               RK_LIM_HI:  rd_data = {24'h0, cfg_q[w].lim_mb[MB_W-1:MB_LO_W]};
               default:    rd_data = '0;
            endcase
         end
      end
   end

   assign cfg = cfg_q;

endmodule

// File: rtl/obwin_match.sv
module obwin_match
   import obwin_pkg::*;
#(
   parameter int unsigned BUS_AW = 64
) (
   input  win_cfg_t            cfg,
   input  logic [CPU_AW-1:0]   cpu_addr,
   output logic                hit,
   output logic [BUS_AW-1:0]   xlat
);

   logic [MB_W-1:0]   mb_num;
   logic              enabled;
   logic              above_base;
   logic              below_lim;
   logic [CPU_AW-1:0] win_start;
   logic [CPU_AW-1:0] offset;

   assign mb_num     = cpu_addr[CPU_AW-1:MB_SHIFT];
   assign enabled    = (cfg.base_mb <= cfg.lim_mb);
   assign above_base = (mb_num >= cfg.base_mb);
   assign below_lim  = (mb_num <= cfg.lim_mb);
   assign hit        = enabled && above_base && below_lim;

   assign win_start  = {cfg.base_mb, {MB_SHIFT{1'b0}}};
   assign offset     = cpu_addr - win_start;
   assign xlat       = cfg.tgt[BUS_AW-1:0] + BUS_AW'(offset);

endmodule

// File: rtl/obwin_prio.sv
module obwin_prio
   import obwin_pkg::*;
#(
   parameter int unsigned NUM_WIN = 4,
   parameter int unsigned BUS_AW  = 64,
   parameter int unsigned IDX_W   = 2
) (
   input  logic [NUM_WIN-1:0]             hits,
   input  logic [NUM_WIN-1:0][BUS_AW-1:0] xlat,
   input  logic [CPU_AW-1:0]              cpu_addr,
   output logic                           any_hit,
   output logic [IDX_W-1:0]               idx,
   output logic [BUS_AW-1:0]              bus
);

   // Scan from the top down so the lowest matching window is the last to win.
   always_comb begin
      any_hit = 1'b0;
      idx     = '0;
      bus     = BUS_AW'(cpu_addr);
      for (int w = NUM_WIN - 1; w >= 0; w--) begin
         if (hits[w]) begin
            any_hit = 1'b1;
            idx     = IDX_W'(w);
            bus     = xlat[w];
         end
      end
   end

endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate
   import obwin_pkg::*;
#(
   parameter int unsigned NUM_WIN = 4,
   parameter int unsigned BUS_AW  = 64,
   parameter bit          OUT_REG = 1'b1,
   parameter int unsigned IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
   parameter int unsigned WA_W    = $clog2(5 * NUM_WIN)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [WA_W-1:0]     wr_addr,
   input  logic [31:0]         wr_data,
   input  logic [WA_W-1:0]     rd_addr,
   output logic [31:0]         rd_data,
   input  logic                in_valid,
   input  logic [CPU_AW-1:0]   cpu_addr,
   output logic                out_valid,
   output logic                hit,
   output logic                miss,
   output logic [IDX_W-1:0]    win_idx,
   output logic [BUS_AW-1:0]   bus_addr
);

   localparam int unsigned MIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
   localparam int unsigned MIN_WA_W  = $clog2(5 * NUM_WIN);

   if (NUM_WIN < 1 || NUM_WIN > 64) begin : g_bad_num_win
      $error("obwin_xlate: NUM_WIN must be within 1..64");
   end
   if (BUS_AW < CPU_AW || BUS_AW > TGT_W) begin : g_bad_bus_aw
      $error("obwin_xlate: BUS_AW must lie between the CPU width and 64");
   end
   if (IDX_W < MIN_IDX_W) begin : g_bad_idx_w
      $error("obwin_xlate: IDX_W too narrow for NUM_WIN");
   end
   if (WA_W < MIN_WA_W) begin : g_bad_wa_w
      $error("obwin_xlate: WA_W too narrow for the register map");
   end

   win_cfg_t [NUM_WIN-1:0]        cfg;
   logic [NUM_WIN-1:0]            win_hit;
   logic [NUM_WIN-1:0][BUS_AW-1:0] win_xlat;
   logic                          any_hit;
   logic [IDX_W-1:0]              sel_idx;
   logic [BUS_AW-1:0]             sel_bus;

   obwin_regs #(
      .NUM_WIN (NUM_WIN),
      .WA_W    (WA_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .cfg     (cfg)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      obwin_match #(
         .BUS_AW (BUS_AW)
      ) u_match (
         .cfg      (cfg[w]),
         .cpu_addr (cpu_addr),
         .hit      (win_hit[w]),
         .xlat     (win_xlat[w])
      );
   end

   obwin_prio #(
      .NUM_WIN (NUM_WIN),
      .BUS_AW  (BUS_AW),
      .IDX_W   (IDX_W)
   ) u_prio (
      .hits     (win_hit),
      .xlat     (win_xlat),
      .cpu_addr (cpu_addr),
      .any_hit  (any_hit),
      .idx      (sel_idx),
      .bus      (sel_bus)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            hit       <= 1'b0;
            miss      <= 1'b0;
            win_idx   <= '0;
            bus_addr  <= '0;
         end else begin
            out_valid <= in_valid;
            hit       <= in_valid && any_hit;
            miss      <= in_valid && !any_hit;
            win_idx   <= sel_idx;
            bus_addr  <= sel_bus;
         end
      end
   end else begin : g_out_comb
      assign out_valid = in_valid;
      assign hit       = in_valid && any_hit;
      assign miss      = in_valid && !any_hit;
      assign win_idx   = sel_idx;
      assign bus_addr  = sel_bus;
   end

endmodule

// File: rtl/obwin_xlate_chk.sv
module obwin_xlate_chk
   import obwin_pkg::*;
#(
   parameter int unsigned BUS_AW  = 64,
   parameter int unsigned IDX_W   = 2,
   parameter bit          OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [CPU_AW-1:0] cpu_addr,
   input logic              out_valid,
   input logic              hit,
   input logic              miss,
   input logic [IDX_W-1:0]  win_idx,
   input logic [BUS_AW-1:0] bus_addr
);

   AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit && miss)); // R9

   AST_VALID_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (hit || miss)); // R10

   AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!hit && !miss)); // R10

   AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      miss |-> (win_idx == '0)); // R9

   if (OUT_REG) begin : g_reg_props
      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid); // R10

      AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid); // R10

      AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
         miss |-> (bus_addr == BUS_AW'($past(cpu_addr)))); // R9
   end else begin : g_comb_props
      AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
         miss |-> (bus_addr == BUS_AW'(cpu_addr))); // R9
   end

endmodule

bind obwin_xlate obwin_xlate_chk #(
   .BUS_AW  (BUS_AW),
   .IDX_W   (IDX_W),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .cpu_addr  (cpu_addr),
   .out_valid (out_valid),
   .hit       (hit),
   .miss      (miss),
   .win_idx   (win_idx),
   .bus_addr  (bus_addr)
);

// File: tb/tb_obwin_xlate.sv
`timescale 1ns/1ps
module tb_obwin_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [4:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        in_valid = 1'b0;
   logic [39:0] cpu_addr = '0;
   logic        out_valid;
   logic        hit;
   logic        miss;
   logic [1:0]  win_idx;
   logic [63:0] bus_addr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   obwin_xlate dut (
      .clk (clk), .rst_n (rst_n),
      .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
      .rd_addr (rd_addr), .rd_data (rd_data),
      .in_valid (in_valid), .cpu_addr (cpu_addr),
      .out_valid (out_valid), .hit (hit), .miss (miss),
      .win_idx (win_idx), .bus_addr (bus_addr)
   );

   // Bench model of the window registers
   logic [63:0] m_tgt  [4];
   logic [19:0] m_base [4];
   logic [19:0] m_lim  [4];

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(input int a);
      if (a < 8)  return a[0] ? m_tgt[a/2][63:32] : m_tgt[a/2][31:0];
      if (a < 12) return {m_lim[a-8][11:0], 4'h0, m_base[a-8][11:0], 4'h0};
      if (a < 20) return (a - 12) % 2 ? {24'h0, m_lim[(a-12)/2][19:12]}
                                      : {24'h0, m_base[(a-12)/2][19:12]};
      return 32'h0;
   endfunction

   function automatic void m_write(input int a, input logic [31:0] d);
      if (a < 8) begin
         if (a[0]) m_tgt[a/2][63:32] = d; else m_tgt[a/2][31:0] = d;
      end else if (a < 12) begin
         m_base[a-8][11:0] = d[15:4];
         m_lim[a-8][11:0]  = d[31:20];
      end else if (a < 20) begin
         if ((a - 12) % 2) m_lim[(a-12)/2][19:12] = d[7:0];
         else              m_base[(a-12)/2][19:12] = d[7:0];
      end
   endfunction

   function automatic void m_lookup(input logic [39:0] a, output logic h,
                                    output logic [1:0] i, output logic [63:0] b);
      h = 1'b0; i = 2'd0; b = {24'h0, a};
      for (int w = 3; w >= 0; w--) begin
         if (m_base[w] <= m_lim[w] && a[39:20] >= m_base[w] && a[39:20] <= m_lim[w]) begin
            h = 1'b1;
            i = 2'(w);
            b = m_tgt[w] + {24'h0, a - {m_base[w], 20'h0}};
         end
      end
   endfunction

   task automatic do_write(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      m_write(a, d);
   endtask

   task automatic check_read(input int a, input string req);
      @(negedge clk);
      rd_addr = 5'(a);
      #2;
      chk(req, $sformatf("rd word %0d", a), {32'h0, rd_data}, {32'h0, m_read(a)});
   endtask

   task automatic check_result(input logic [39:0] a, input logic eh,
                               input logic [1:0] ei, input logic [63:0] eb,
                               input string req);
      chk(req, "out_valid", {63'h0, out_valid}, 64'h1);
      chk(req, "hit", {63'h0, hit}, {63'h0, eh});
      chk(req, "miss", {63'h0, miss}, {63'h0, !eh});
      chk(req, "win_idx", {62'h0, win_idx}, {62'h0, ei});
      chk(req, $sformatf("bus_addr for 0x%0h", a), bus_addr, eb);
   endtask

   task automatic do_lookup(input logic [39:0] a, input string req);
      logic eh; logic [1:0] ei; logic [63:0] eb;
      m_lookup(a, eh, ei, eb);
      @(negedge clk);
      in_valid = 1'b1; cpu_addr = a;
      @(negedge clk);
      in_valid = 1'b0;
      check_result(a, eh, ei, eb, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic eh; logic [1:0] ei; logic [63:0] eb;
      void'($urandom(32'h0B0E_5EED));
      for (int w = 0; w < 4; w++) begin
         m_tgt[w] = '0; m_base[w] = 20'hFFFFF; m_lim[w] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R4: reset state of outputs and registers
      @(negedge clk);
      chk("R4", "out_valid", {63'h0, out_valid}, 64'h0);
      chk("R4", "hit", {63'h0, hit}, 64'h0);
      chk("R4", "miss", {63'h0, miss}, 64'h0);
      for (int a = 0; a < 20; a++) check_read(a, "R4");
      do_lookup(40'h00_0000_1234, "R4");

      // R11: unmapped words
      for (int a = 20; a < 32; a++) do_write(a, 32'hFFFF_FFFF);
      for (int a = 0; a < 32; a++) check_read(a, "R11");

      // R1, R2, R3: programming and readback
      do_write(0, 32'h3450_0000); do_write(1, 32'h0000_0012);
      do_write(8, 32'h01FF_010F);
      check_read(8, "R2");
      do_write(12, 32'hFFFF_FF00); do_write(13, 32'hAAAA_AA00);
      check_read(12, "R3"); check_read(13, "R3");
      do_write(2, 32'hA000_0000); do_write(3, 32'h0);
      do_write(9, {12'h030, 4'h0, 12'h018, 4'h0});
      do_write(14, 32'h0); do_write(15, 32'h0);
      do_write(4, 32'h5555_0000); do_write(5, 32'h7);
      do_write(10, {12'h0FF, 4'h0, 12'h100, 4'h0});
      do_write(16, 32'h0); do_write(17, 32'h0);
      do_write(6, 32'hFFF0_0000); do_write(7, 32'hFFFF_FFFF);
      do_write(11, {12'h346, 4'h0, 12'h345, 4'h0});
      do_write(18, 32'h12); do_write(19, 32'h12);
      for (int a = 0; a < 8; a++) check_read(a, "R1");
      check_read(11, "R2"); check_read(18, "R3"); check_read(19, "R3");

      // R5: inclusive bounds
      do_lookup(40'h00_0100_0000, "R5");
      do_lookup(40'h00_01FF_FFFF, "R5");
      do_lookup(40'h00_00FF_FFFF, "R5");
      do_lookup(40'h00_0310_0000, "R5");
      // R7: overlap of windows 0 and 1
      do_lookup(40'h00_0180_0000, "R7");
      do_lookup(40'h00_0250_1234, "R7");
      // R8: window 2 has limit below base
      do_lookup(40'h00_1000_0000, "R8");
      do_lookup(40'h00_0FF0_0000, "R8");
      // R6: high megabyte bits and wrap of the target sum
      do_lookup(40'h12_3460_0010, "R6");
      do_lookup(40'h12_3450_0000, "R6");
      // R9: miss with high bits set
      do_lookup(40'hFF_FFFF_FFFF, "R9");

      // R10: idle cycle after a lookup
      @(negedge clk);
      chk("R10", "idle out_valid", {63'h0, out_valid}, 64'h0);
      chk("R10", "idle hit/miss", {62'h0, hit, miss}, 64'h0);

      // R12: write and lookup together, then lookup alone
      m_lookup(40'h00_1000_0000, eh, ei, eb);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'd10; wr_data = {12'h100, 4'h0, 12'h100, 4'h0};
      in_valid = 1'b1; cpu_addr = 40'h00_1000_0000;
      @(negedge clk);
      wr_en = 1'b0;
      m_write(10, {12'h100, 4'h0, 12'h100, 4'h0});
      check_result(40'h00_1000_0000, eh, ei, eb, "R12");
      m_lookup(40'h00_1000_0000, eh, ei, eb);
      @(negedge clk);
      in_valid = 1'b0;
      check_result(40'h00_1000_0000, eh, ei, eb, "R12");
      chk("R12", "new window hit", {63'h0, hit}, 64'h1);

      // Random mix: R5 R6 R7 R8 R9 against the model
      for (int n = 0; n < 600; n++) begin
         int unsigned sel;
         sel = $urandom_range(0, 9);
         if (sel < 3) begin
            int a;
            logic [31:0] d;
            a = $urandom_range(0, 19);
            d = $urandom;
            if (a >= 8 && a < 12) begin
               d[31:20] = 12'($urandom_range(0, 63));
               d[15:4]  = 12'($urandom_range(0, 63));
            end else if (a >= 12 && $urandom_range(0, 7) != 0) begin
               d[7:0] = 8'h0;
            end
            do_write(a, d);
         end else if (sel == 3) begin
            check_read($urandom_range(0, 31), "R1");
         end else begin
            logic [39:0] ra;
            ra = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
            if ($urandom_range(0, 7) != 0) ra[39:20] = 20'($urandom_range(0, 70));
            do_lookup(ra, "R6");
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule